// File: doc/BRIEF.md
# Console Terminal Controller

This block sits between a processor's I/O path and a separate UART that handles the serial line coding. It manages two independent directions. On the receive side, characters arrive from the UART as single-cycle byte strobes. Each character is converted, latched into an input buffer, and flagged as available. On the transmit side, the processor writes a character into an output buffer. The block then offers the converted character to the UART over a valid/ready handshake and keeps offering it until the UART takes it.

Each direction has a ready flag. The processor can see these flags in three ways:
- a sense query that returns one bit for any chosen subset of the flags;
- a function-out command that clears selected flags;
- a combined interrupt request, formed from the flags and two externally held enable bits.

A single character-mode setting governs the conversion in both directions. The modes are a keyboard-printer mode (upper case only, 7 bits), a plain 7-bit mode and a transparent 8-bit mode.

Top module: `con_term_if`

## Requirements
- R1: After reset the input buffer reads 0, input-ready is clear, output-ready is set, `txValid` is low and the mode is keyboard-printer (code 0).
- R2: A CPU write keeps only bits [7:0] of `wrData` in the output buffer. One cycle later output-ready is clear and `txValid` is high.
- R3: While `txValid` is high and `txReady` is low, `txValid` stays high and output-ready stays clear. On the edge where both are high, the character is accepted. From the next cycle `txValid` is low and output-ready is set.
- R4: A receive strobe (`rxValid`) stores the converted `rxData` in the input buffer and sets input-ready. If `rxBreak` is high with the strobe, the value 0 is stored instead.
- R5: Function-out bit 0 clears input-ready and bit 1 clears output-ready; both may be set in one command. A receive strobe in the same cycle wins over the input-ready clear. A write or a completed transfer in the same cycle wins over the output-ready clear.
- R6: `senseFlag` is 1 when input-ready is set and `senseSel[0]` is 1, or when output-ready is set and `senseSel[1]` is 1. Otherwise it is 0.
- R7: `irq` is high when (input-ready AND `intEnable[0]`) OR (output-ready AND `intEnable[1]`).
- R8: Mode codes on `modeVal` are: 0 keyboard-printer, 1 seven-bit, 2 and 3 eight-bit. A mode write takes effect from the next cycle. In eight-bit mode characters pass unchanged.
- R9: In seven-bit mode, bit 7 is cleared on both received and transmitted characters.
- R10: In keyboard-printer mode, bit 7 is cleared and then the codes 0x61..0x7A are lowered by 0x20. All other codes are unchanged.
- R11: The one mode setting applies to both directions. The transmit side converts the buffered character with the mode in force while it is being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One-cycle strobe: a received character is present |
| rxData | input | 8 | Received character |
| rxBreak | input | 1 | Received line break (qualifies rxValid) |
| txValid | output | 1 | Character offered to the transmitter |
| txData | output | 8 | Converted character to transmit |
| txReady | input | 1 | Transmitter accepts the character |
| cpuWrite | input | 1 | CPU write of the output buffer |
| wrData | input | CPU_W (16) | CPU write data, low 8 bits kept |
| rdData | output | CPU_W (16) | Input buffer, zero extended |
| fnOut | input | 1 | Function-out command strobe |
| fnBits | input | 2 | bit0 clear input-ready, bit1 clear output-ready |
| senseSel | input | 2 | bit0 selects input-ready, bit1 selects output-ready |
| senseFlag | output | 1 | Sense result |
| modeWr | input | 1 | Write the character mode |
| modeVal | input | 2 | New character mode code |
| intEnable | input | 2 | bit0 input interrupt enable, bit1 output interrupt enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest state to reach is a transmit character that stays outstanding while other activity happens around it. This is only visible when the transmitter withholds `txReady`. The bench drives `txReady` low for several cycles after a write and checks that the offer and the cleared output-ready both persist. It then lets the character through and checks the edge where output-ready returns. Coincident set and clear events are produced by driving `rxValid` and a function-out clear in the same cycle. A scoreboard queue holds the expected converted bytes and matches them at each handshake.

// File: rtl/con_term_pkg.sv
package con_term_pkg;

  localparam int CHAR_W = 8;
  localparam int FN_CLR_IN  = 0;
  localparam int FN_CLR_OUT = 1;

  typedef enum logic [1:0] {
    MODE_KSR   = 2'd0,
    MODE_7BIT  = 2'd1,
    MODE_8BIT  = 2'd2,
    MODE_8BITB = 2'd3
  } charMode_t;

  typedef struct packed {
    logic loadIn;
    logic zeroIn;
    logic loadOut;
    logic loadMode;
  } dpStrobe_t;

  function automatic logic [CHAR_W-1:0] convChar(input logic [CHAR_W-1:0] c,
                                                 input charMode_t m);
    logic [CHAR_W-1:0] r;
    r = c;
    if (m == MODE_KSR || m == MODE_7BIT) r[CHAR_W-1] = 1'b0;
    if (m == MODE_KSR && r >= 8'h61 && r <= 8'h7A) r = r - 8'h20;
    return r;
  endfunction

endpackage

// File: rtl/con_term_ctrl.sv
module con_term_ctrl
  import con_term_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxBreak,
  input  logic       cpuWrite,
  input  logic       modeWr,
  input  logic       fnOut,
  input  logic [1:0] fnBits,
  input  logic [1:0] senseSel,
  input  logic [1:0] intEnable,
  input  logic       txReady,
  output logic       txValid,
  output logic       senseFlag,
  output logic       irq,
  output dpStrobe_t  strobe
);

  localparam int NUM_DIR = 2;

  logic inRdy;
  logic outRdy;
  logic txPending;
  logic [NUM_DIR-1:0] readyVec;
  logic [NUM_DIR-1:0] senseHit;
  logic [NUM_DIR-1:0] reqVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inRdy     <= 1'b0;
      outRdy    <= 1'b1;
      txPending <= 1'b0;
    end else begin
      if (rxValid)
        inRdy <= 1'b1;
      else if (fnOut && fnBits[FN_CLR_IN])
        inRdy <= 1'b0;

      if (cpuWrite) begin
        outRdy    <= 1'b0;
        txPending <= 1'b1;
      end else if (txPending && txReady) begin
        txPending <= 1'b0;
        outRdy    <= 1'b1;
      end else if (fnOut && fnBits[FN_CLR_OUT]) begin
        outRdy <= 1'b0;
      end
    end
  end

  assign readyVec = {outRdy, inRdy};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    assign senseHit[d] = readyVec[d] & senseSel[d];
    assign reqVec[d]   = readyVec[d] & intEnable[d];
  end

  assign senseFlag = |senseHit;
  assign irq       = |reqVec;
  assign txValid   = txPending;

  always_comb begin
    strobe          = '0;
    strobe.loadIn   = rxValid;
    strobe.zeroIn   = rxValid & rxBreak;
    strobe.loadOut  = cpuWrite;
    strobe.loadMode = modeWr;
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !cpuWrite) |=> (txValid && !outRdy)); // R3
  AST_TX_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && !cpuWrite) |=> (!txValid && outRdy)); // R3
  AST_PEND_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(txValid && outRdy)); // R3
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrite |=> (!outRdy && txValid)); // R2
  AST_RX_SETS: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> inRdy); // R4
  AST_FN_CLR_IN: assert property (@(posedge clk) disable iff (!rstN)
    (fnOut && fnBits[FN_CLR_IN] && !rxValid) |=> !inRdy); // R5

endmodule

// File: rtl/con_term_dp.sv
module con_term_dp
  import con_term_pkg::*;
#(
  parameter int CPU_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CHAR_W-1:0] rxData,
  input  logic [CPU_W-1:0]  wrData,
  input  logic [1:0]        modeVal,
  output logic [CPU_W-1:0]  rdData,
  output logic [CHAR_W-1:0] txData
);

  logic [CHAR_W-1:0] inBuf;
  logic [CHAR_W-1:0] outBuf;
  charMode_t         modeReg;
  logic              unusedWrHi;

  assign unusedWrHi = ^wrData[CPU_W-1:CHAR_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBuf   <= '0;
      outBuf  <= '0;
      modeReg <= MODE_KSR;
    end else begin
      if (strobe.loadIn)
        inBuf <= strobe.zeroIn ? '0 : convChar(rxData, modeReg);
      if (strobe.loadOut)
        outBuf <= wrData[CHAR_W-1:0];
      if (strobe.loadMode)
        modeReg <= charMode_t'(modeVal);
    end
  end

  assign rdData = {{(CPU_W-CHAR_W){1'b0}}, inBuf};
  assign txData = convChar(outBuf, modeReg);

  AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadIn && strobe.zeroIn) |=> (inBuf == '0)); // R4
  AST_WRITE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |=> (outBuf == $past(wrData[CHAR_W-1:0]))); // R2
  AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[CPU_W-1:CHAR_W] == '0); // R1
  AST_SEVEN_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg != MODE_8BIT && modeReg != MODE_8BITB) |-> !txData[CHAR_W-1]); // R9

endmodule

// File: rtl/con_term_if.sv
module con_term_if
  import con_term_pkg::*;
#(
  parameter int CPU_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             rxBreak,
  output logic             txValid,
  output logic [7:0]       txData,
  input  logic             txReady,
  input  logic             cpuWrite,
  input  logic [CPU_W-1:0] wrData,
  output logic [CPU_W-1:0] rdData,
  input  logic             fnOut,
  input  logic [1:0]       fnBits,
  input  logic [1:0]       senseSel,
  output logic             senseFlag,
  input  logic             modeWr,
  input  logic [1:0]       modeVal,
  input  logic [1:0]       intEnable,
  output logic             irq
);

  dpStrobe_t strobe;

  con_term_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxValid   (rxValid),
    .rxBreak   (rxBreak),
    .cpuWrite  (cpuWrite),
    .modeWr    (modeWr),
    .fnOut     (fnOut),
    .fnBits    (fnBits),
    .senseSel  (senseSel),
    .intEnable (intEnable),
    .txReady   (txReady),
    .txValid   (txValid),
    .senseFlag (senseFlag),
    .irq       (irq),
    .strobe    (strobe)
  );

  con_term_dp #(.CPU_W(CPU_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rxData  (rxData),
    .wrData  (wrData),
    .modeVal (modeVal),
    .rdData  (rdData),
    .txData  (txData)
  );

endmodule

// File: tb/test_con_term_if.sv
module test_con_term_if;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxBreak = 1'b0;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic        cpuWrite = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        fnOut = 1'b0;
  logic [1:0]  fnBits = '0;
  logic [1:0]  senseSel = '0;
  logic        senseFlag;
  logic        modeWr = 1'b0;
  logic [1:0]  modeVal = '0;
  logic [1:0]  intEnable = '0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  int benchMode = 0;

  always #4 clk = ~clk;

  con_term_if i_con_term_if (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxBreak(rxBreak),
    .txValid(txValid), .txData(txData), .txReady(txReady), .cpuWrite(cpuWrite),
    .wrData(wrData), .rdData(rdData), .fnOut(fnOut), .fnBits(fnBits),
    .senseSel(senseSel), .senseFlag(senseFlag), .modeWr(modeWr), .modeVal(modeVal),
    .intEnable(intEnable), .irq(irq)
  );

  function automatic logic [7:0] expConv(input logic [7:0] c, input int m);
    logic [7:0] v;
    if (m >= 2) return c;
    v = c & 8'h7F;
    if (m == 0 && v >= "a" && v <= "z") v = v - ("a" - "A");
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic readySense(input logic [1:0] sel, output logic val);
    senseSel = sel;
    #1 val = senseFlag;
  endtask

  task automatic rxChar(input logic [7:0] c, input logic brk);
    @(negedge clk);
    rxValid = 1'b1; rxData = c; rxBreak = brk;
    @(negedge clk);
    rxValid = 1'b0; rxBreak = 1'b0;
  endtask

  task automatic cpuWr(input logic [15:0] v);
    @(negedge clk);
    cpuWrite = 1'b1; wrData = v;
    expQ.push_back(expConv(v[7:0], benchMode));
    @(negedge clk);
    cpuWrite = 1'b0;
  endtask

  task automatic setMode(input int m);
    @(negedge clk);
    modeWr = 1'b1; modeVal = m[1:0];
    @(negedge clk);
    modeWr = 1'b0;
    benchMode = m;
  endtask

  // scoreboard monitor: compare each accepted character against the queue
  always @(posedge clk) begin
    if (rstN && txValid && txReady) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R2/R11: unexpected tx actual %0h expected none", txData);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (txData !== e) begin
          fails++;
          $display("FAIL R11 tx char: actual %0h expected %0h", txData, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdData", rdData, 0);
    chk("R1 txValid", txValid, 0);
    readySense(2'b01, s); chk("R1 input-ready", s, 0);
    readySense(2'b10, s); chk("R1 output-ready", s, 1);
    // R7 irq
    intEnable = 2'b01; #1 chk("R7 irq in-only", irq, 0);
    intEnable = 2'b10; #1 chk("R7 irq out-only", irq, 1);

    // R10 keyboard-printer conversion (default mode)
    rxChar(8'h61, 0); chk("R10 fold a", rdData, 16'h41);
    readySense(2'b01, s); chk("R4 input-ready set", s, 1);
    intEnable = 2'b01; #1 chk("R7 irq input", irq, 1);
    rxChar(8'hE2, 0); chk("R10 bit7 and fold", rdData, 16'h42);
    rxChar(8'h7B, 0); chk("R10 brace kept", rdData, 16'h7B);
    rxChar(8'h60, 0); chk("R10 backquote kept", rdData, 16'h60);
    // R4 break stores zero
    rxChar(8'h55, 1); chk("R4 break zero", rdData, 0);

    // R5 clear input-ready
    @(negedge clk); fnOut = 1'b1; fnBits = 2'b01;
    @(negedge clk); fnOut = 1'b0;
    readySense(2'b01, s); chk("R5 clear in", s, 0);
    readySense(2'b10, s); chk("R5 out untouched", s, 1);
    #1 chk("R7 irq cleared", irq, 0);

    // R2/R3 write with transmitter stalled
    txReady = 1'b0;
    cpuWr(16'h1234);
    chk("R2 txValid", txValid, 1);
    readySense(2'b10, s); chk("R2 out-ready clear", s, 0);
    repeat (5) @(negedge clk);
    chk("R3 hold valid", txValid, 1);
    readySense(2'b10, s); chk("R3 hold out-ready", s, 0);
    chk("R2 low byte", txData, 8'h34);
    txReady = 1'b1;
    @(negedge clk);
    chk("R3 valid drops", txValid, 0);
    readySense(2'b10, s); chk("R3 out-ready back", s, 1);

    // R9 seven-bit mode both directions
    setMode(1);
    cpuWr(16'hABE1);
    rxChar(8'hE1, 0); chk("R9 rx bit7", rdData, 16'h61);

    // R8 eight-bit modes
    setMode(2);
    cpuWr(16'h00E1);
    rxChar(8'hFF, 0); chk("R8 rx pass", rdData, 16'hFF);
    setMode(3);
    rxChar(8'h80, 0); chk("R8 code 3 pass", rdData, 16'h80);

    // R5 both bits at once
    @(negedge clk); fnOut = 1'b1; fnBits = 2'b11;
    @(negedge clk); fnOut = 1'b0;
    readySense(2'b11, s); chk("R5 both cleared", s, 0);
    // R5 receive wins over clear
    @(negedge clk); fnOut = 1'b1; fnBits = 2'b01; rxValid = 1'b1; rxData = 8'h33;
    @(negedge clk); fnOut = 1'b0; rxValid = 1'b0;
    readySense(2'b01, s); chk("R5 rx wins", s, 1);
    chk("R5 rx stored", rdData, 16'h33);

    // R10/R11 back to keyboard-printer for output
    setMode(0);
    cpuWr(16'h007A);
    @(negedge clk);
    readySense(2'b10, s); chk("R6 out-ready after tx", s, 1);
    readySense(2'b00, s); chk("R6 none selected", s, 0);

    repeat (3) @(negedge clk);
    chk("R11 queue drained", expQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule